// File: doc/BRIEF.md
# Write Status Polling Responder

This block sits in the read path of a flash-style memory. It takes over the output byte while an internal program or erase is in progress. The command decoder pulses `start` after the last write of a command sequence and gives it the operation kind and the top bit of the byte being written. From that point the block counts out a per-operation duration and holds `busy` high for that time. While `busy` is high it does not pass array data through. It returns a status byte instead. Bit 7 carries the inverted programmed bit during a program and a fixed 0 during an erase. Bit 6 flips on every new read access.

After a program, a short settle window follows. In that window bit 7 already shows the true programmed value, but the rest of the byte is not yet trustworthy. Once the settle window has passed, and at any other time, the output is the array read data unchanged. Software polls the byte in one of two ways: it waits until bit 7 matches what it wrote, or until two successive reads return the same bit 6.

Durations are parameters in clock cycles: `PROG_CYC`, `ERASE_CYC` (sector and block), `CHIP_CYC` and `SETTLE_CYC`. Each must be at least 1.

Top module: `wr_status_resp`

## Requirements
- R1: While `rst_n` is low and after its release, `busy` is 0, the toggle state is 0 and `dq_out` equals `arr_data`.
- R2: A `start` accepted at a clock edge keeps `busy` high for exactly the next D cycles. D is `PROG_CYC` for `op_kind` 2'b00 (program), `ERASE_CYC` for 2'b01 (sector erase) and 2'b10 (block erase), and `CHIP_CYC` for 2'b11 (chip erase).
- R3: While busy with a program, `dq_out[7]` is the inverse of the `prog_msb` value sampled with `start`.
- R4: While busy with any erase, `dq_out[7]` is 0.
- R5: While busy, `dq_out[6]` changes after every rising edge of `rd_stb` (a cycle with `rd_stb` high following one with it low) and only then. Holding `rd_stb` high counts as one read.
- R6: While busy, `dq_out[5:0]` is 0.
- R7: When not busy, `rd_stb` does not change the toggle state. The held value shows in bit 6 of the settle window and is the starting value of bit 6 in the next operation.
- R8: For `SETTLE_CYC` cycles after a program ends, `busy` is 0 and `dq_out` is {sampled `prog_msb`, held toggle, 6'b0}. After that, `dq_out` follows `arr_data`.
- R9: In the first cycle after an erase ends, `dq_out` equals `arr_data`. An erased location therefore reads FFh.
- R10: A `start` while `busy` is high is ignored. The operation kind, the sampled bit and the remaining duration are all unchanged.
- R11: Status replaces array data in the very first cycle after the edge that accepts `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse: internal operation begins |
| op_kind | input | 2 | 00 program, 01 sector erase, 10 block erase, 11 chip erase |
| prog_msb | input | 1 | Bit 7 of the byte being programmed |
| rd_stb | input | 1 | Read access strobe, level high during a read |
| arr_data | input | 8 | Array read data |
| busy | output | 1 | Internal operation in progress |
| dq_out | output | 8 | Byte returned on a read |

## Verification
A wrong duration count shows as `busy` falling one or more cycles early or late. The same error shifts the point where bit 7 flips from status back to data. It is therefore visible at the first cycle boundary after the expected end. A toggle state that advances on a level instead of an edge, or that advances while idle, shows on the next read as a bit 6 value that disagrees with the count of read edges. A wrongly latched operation kind or bit shows on bit 7 in the very first busy cycle. The settle window exposes errors in bit 7 and in the held toggle together, before array data returns.

// File: rtl/wr_status_resp.sv
`timescale 1ns/1ps
module wr_status_resp #(
  parameter int PROG_CYC   = 20,
  parameter int ERASE_CYC  = 100,
  parameter int CHIP_CYC   = 300,
  parameter int SETTLE_CYC = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] op_kind,
  input  logic       prog_msb,
  input  logic       rd_stb,
  input  logic [7:0] arr_data,
  output logic       busy,
  output logic [7:0] dq_out
);
  localparam int MAXC = (PROG_CYC > ERASE_CYC) ?
                        ((PROG_CYC > CHIP_CYC) ? PROG_CYC : CHIP_CYC) :
                        ((ERASE_CYC > CHIP_CYC) ? ERASE_CYC : CHIP_CYC);
  localparam int CW = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam int SW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;

  logic          busy_q, settle_q, tog_q, rd_q, msb_q;
  logic [1:0]    kind_q;
  logic [CW-1:0] cnt_q;
  logic [SW-1:0] scnt_q;

  wire accept  = start & ~busy_q;
  wire rd_rise = rd_stb & ~rd_q;
  wire is_prog = (kind_q == 2'b00);

  function automatic logic [CW-1:0] dur_load(input logic [1:0] k);
    case (k)
      2'b00:   return CW'(PROG_CYC - 1);
      2'b11:   return CW'(CHIP_CYC - 1);
      default: return CW'(ERASE_CYC - 1);
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      settle_q <= 1'b0;
      tog_q    <= 1'b0;
      rd_q     <= 1'b0;
      msb_q    <= 1'b0;
      kind_q   <= 2'b00;
      cnt_q    <= '0;
      scnt_q   <= '0;
    end else begin
      rd_q <= rd_stb;
      if (busy_q && rd_rise) tog_q <= ~tog_q;
      if (accept) begin
        busy_q   <= 1'b1;
        settle_q <= 1'b0;
        kind_q   <= op_kind;
        msb_q    <= prog_msb;
        cnt_q    <= dur_load(op_kind);
      end else if (busy_q) begin
        if (cnt_q == '0) begin
          busy_q <= 1'b0;
          if (is_prog) begin
            settle_q <= 1'b1;
            scnt_q   <= SW'(SETTLE_CYC - 1);
          end
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end else if (settle_q) begin
        if (scnt_q == '0) settle_q <= 1'b0;
        else              scnt_q   <= scnt_q - 1'b1;
      end
    end
  end

  assign busy = busy_q;

  always_comb begin
    if (busy_q)        dq_out = {is_prog & ~msb_q, tog_q, 6'b0};
    else if (settle_q) dq_out = {msb_q, tog_q, 6'b0};
    else               dq_out = arr_data;
  end
endmodule

// File: rtl/wr_status_resp_chk.sv
`timescale 1ns/1ps
module wr_status_resp_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       rd_stb,
  input logic       busy,
  input logic [7:0] dq_out,
  input logic [1:0] kind_q,
  input logic       msb_q,
  input logic       tog_q,
  input logic       rd_q,
  input logic       cnt_zero
);
  // R11
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);
  // R3
  prog_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && kind_q == 2'b00 |-> dq_out[7] == !msb_q);
  // R4
  erase_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && kind_q != 2'b00 |-> !dq_out[7]);
  // R6
  low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> dq_out[5:0] == 6'b0);
  // R5
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && rd_stb && !rd_q && !cnt_zero |=> dq_out[6] != $past(dq_out[6]));
  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(tog_q));
  // R10
  busy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !cnt_zero |=> busy && $stable(kind_q) && $stable(msb_q));
endmodule

bind wr_status_resp wr_status_resp_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .rd_stb(rd_stb), .busy(busy),
  .dq_out(dq_out), .kind_q(kind_q), .msb_q(msb_q), .tog_q(tog_q),
  .rd_q(rd_q), .cnt_zero(cnt_q == '0)
);

// File: tb/wr_status_resp_bench.sv
`timescale 1ns/1ps
module wr_status_resp_bench;
  localparam int P_CYC = 20, E_CYC = 100, C_CYC = 300, S_CYC = 4;

  logic clk = 0, rst_n = 0, start = 0, prog_msb = 0, rd_stb = 0;
  logic [1:0] op_kind = 0;
  logic [7:0] arr_data = 0;
  logic busy;
  logic [7:0] dq_out;
  int checks = 0, failures = 0;
  logic exp_tog = 0, prev_rd = 0;

  wr_status_resp #(.PROG_CYC(P_CYC), .ERASE_CYC(E_CYC), .CHIP_CYC(C_CYC),
                   .SETTLE_CYC(S_CYC)) u_wr_status_resp (
    .clk(clk), .rst_n(rst_n), .start(start), .op_kind(op_kind),
    .prog_msb(prog_msb), .rd_stb(rd_stb), .arr_data(arr_data),
    .busy(busy), .dq_out(dq_out));

  always #5 clk = ~clk;

  function automatic int dur(input logic [1:0] k);
    return (k == 2'b00) ? P_CYC : (k == 2'b11) ? C_CYC : E_CYC;
  endfunction

  function automatic logic exp_b7(input logic [1:0] k, input logic b);
    return (k == 2'b00) ? ~b : 1'b0;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_cyc(input logic rd);
    @(negedge clk);
    start = 0; rd_stb = rd; arr_data = 8'($urandom);
    #1;
    chk("R9 idle passthrough", dq_out, arr_data);
    chk("R2 busy low when idle", {7'b0, busy}, 8'h00);
    prev_rd = rd;
  endtask

  // rd_mode: 0 random reads, 1 held high, 2 no reads
  task automatic run_op(input logic [1:0] k, input logic b, input int rd_mode, input logic noise);
    int n;
    logic rd, rise;
    n = dur(k);
    @(negedge clk);
    start = 1; op_kind = k; prog_msb = b; rd_stb = 0; arr_data = 8'($urandom);
    #1;
    chk("R9 pre-start passthrough", dq_out, arr_data);
    prev_rd = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      rd = (rd_mode == 0) ? 1'($urandom) : (rd_mode == 1);
      start = noise && ($urandom % 4 == 0);
      op_kind = 2'($urandom); prog_msb = 1'($urandom);
      rd_stb = rd; arr_data = 8'($urandom);
      #1;
      chk(i == 1 ? "R11 busy first cycle" : "R2 busy held", {7'b0, busy}, 8'h01);
      chk(k == 2'b00 ? "R3 program bit7" : "R4 erase bit7", {7'b0, dq_out[7]}, {7'b0, exp_b7(k, b)});
      chk(noise ? "R10 R5 toggle under ignored start" : "R5 toggle bit6", {7'b0, dq_out[6]}, {7'b0, exp_tog});
      chk("R6 low bits zero", {2'b0, dq_out[5:0]}, 8'h00);
      rise = rd && !prev_rd;
      prev_rd = rd;
      if (rise) exp_tog = ~exp_tog;
    end
    if (k == 2'b00) begin
      for (int j = 0; j < S_CYC; j++) begin
        @(negedge clk);
        start = 0; rd = 1'($urandom); rd_stb = rd; arr_data = 8'($urandom);
        #1;
        chk("R2 busy ends", {7'b0, busy}, 8'h00);
        chk("R8 R7 settle byte", dq_out, {b, exp_tog, 6'b0});
        prev_rd = rd;
      end
    end else begin
      @(negedge clk);
      start = 0; rd_stb = 0; arr_data = 8'hFF;
      #1;
      chk("R2 busy ends", {7'b0, busy}, 8'h00);
      chk("R9 erased reads FF", dq_out, 8'hFF);
      prev_rd = 0;
    end
    idle_cyc(1'b1);
    idle_cyc(1'b0);
    idle_cyc(1'b1);
  endtask

  initial begin
    void'($urandom(32'd1234));
    arr_data = 8'h5A;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset output", dq_out, 8'h5A);
    chk("R1 reset busy", {7'b0, busy}, 8'h00);
    @(negedge clk); rst_n = 1;
    idle_cyc(1'b0);
    idle_cyc(1'b1);
    idle_cyc(1'b0);
    // directed corners
    run_op(2'b00, 1'b1, 0, 1'b0);
    run_op(2'b00, 1'b0, 1, 1'b0);
    run_op(2'b01, 1'b0, 2, 1'b0);
    run_op(2'b10, 1'b1, 0, 1'b1);
    run_op(2'b11, 1'b0, 0, 1'b0);
    run_op(2'b00, 1'b1, 0, 1'b1);
    // random mix
    for (int t = 0; t < 40; t++)
      run_op(2'($urandom), 1'($urandom), $urandom % 3, 1'($urandom));
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_800_000;
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule